// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block collects up to 32 level-sensitive interrupt lines and folds them into a single cascade request for an upstream interrupt controller. Each line first passes through a two-stage synchroniser. A programmable polarity bit then decides whether a high or a low level counts as a request. While a line is asserted, its request is captured into a sticky status register. Software clears a status bit by writing a 1 to it.

A per-source enable mask and a global enable bit decide which pending sources drive the registered cascade output. A small 32-bit register bus gives read and write access to the enable, polarity, status and global-enable registers, plus a read-only view of the synchronised inputs. Register bits are ordered with source 0 at the most significant bit. A handler reads the status word, services the sources it finds, clears them with a write-1 and reads again until nothing is left pending.

Top module: `lvl_irq_agg`

## Requirements
- R1: After a synchronous reset, all of the following read as zero and the cascade output is low: status, per-source enable, polarity, global enable and the read data.
- R2: Source n (input `src_in[n]`) appears at register bit 31-n in the status, enable, polarity and raw-input registers, so source 0 is bit 31.
- R3: Register offsets are 0x04 global enable, 0x50 status, 0x54 per-source enable, 0x58 polarity and 0x5C raw input.
- R4: A polarity bit of 0 makes a high level on its input a request. A polarity bit of 1 makes a low level a request.
- R5: Writing to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every bit whose source is no longer requesting.
- R6: The per-source enable, polarity and global enable registers read back the value last written to them.
- R7: A status bit is set on every cycle in which its synchronised, polarity-adjusted input is asserted. If a clear and an assertion fall in the same cycle, the bit stays set.
- R8: The cascade output goes high one cycle after some status bit and its enable bit are both 1 while bit 0 of the global enable is 1. Otherwise it is low.
- R9: The raw-input register shows the inputs after two synchroniser flops and before polarity inversion. Writes to it have no effect.
- R10: Read data is registered and appears one cycle after the address is presented. Unmapped offsets read as zero.
- R11: Writing 0 to the global enable, or 0 to all per-source enables, holds the cascade output low even while status bits are pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NSRC | Asynchronous interrupt lines, index = source number |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data for the previous cycle's address |
| irq_out | output | 1 | Registered cascade interrupt request |

## Verification
The hardest case to reach is a write-1 clear landing in the same cycle as a still-asserted request, where the set must win. The bench reaches it deterministically by programming an inverted polarity on an idle-low line, which makes the source request continuously, then clearing it with all ones and checking that the bit is still there. A random phase then mixes input toggles with writes to every register, so clears collide with fresh assertions and enable changes collide with pending status. A behavioural model checks the cascade and read data on every cycle of that phase.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
  localparam int OFF_ACC  = 'h04;
  localparam int OFF_STAT = 'h50;
  localparam int OFF_EN   = 'h54;
  localparam int OFF_POL  = 'h58;
  localparam int OFF_RAW  = 'h5C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ACC,
    SEL_STAT,
    SEL_EN,
    SEL_POL,
    SEL_RAW
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] status
);
  logic [W-1:0] req;
  logic [W-1:0] status_q;

  assign req = raw ^ pol;

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= req | (status_q & ~clr_mask);
  end

  assign status = status_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import lvl_irq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] en,
  output logic [DW-1:0] pol,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] clr_mask,
  output logic [DW-1:0] rdata
);
  reg_sel_e     sel;
  logic [DW-1:0] en_q, pol_q, acc_q, rd_q, rd_d;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == AW'(OFF_ACC))  sel = SEL_ACC;
    else if (addr == AW'(OFF_STAT)) sel = SEL_STAT;
    else if (addr == AW'(OFF_EN))   sel = SEL_EN;
    else if (addr == AW'(OFF_POL))  sel = SEL_POL;
    else if (addr == AW'(OFF_RAW))  sel = SEL_RAW;
  end

  assign clr_mask = (we && sel == SEL_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      pol_q <= '0;
      acc_q <= '0;
    end else if (we) begin
      if (sel == SEL_EN)  en_q  <= wdata;
      if (sel == SEL_POL) pol_q <= wdata;
      if (sel == SEL_ACC) acc_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ACC:  rd_d = acc_q;
      SEL_STAT: rd_d = status;
      SEL_EN:   rd_d = en_q;
      SEL_POL:  rd_d = pol_q;
      SEL_RAW:  rd_d = raw;
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_d;
  end

  assign en    = en_q;
  assign pol   = pol_q;
  assign acc   = acc_q;
  assign rdata = rd_q;
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] status,
  input  logic [W-1:0] en,
  input  logic         gate,
  output logic         irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= gate && (|(status & en));
  end

  assign irq = irq_q;
endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg #(
  parameter int NSRC        = 32,
  parameter int AW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_out
);
  localparam int DW = NSRC;

  logic [DW-1:0] src_msb;
  logic [DW-1:0] sync_q;
  logic [DW-1:0] status_q, en_q, pol_q, acc_q, clr_mask;

  // source n lands on register bit DW-1-n
  for (genvar n = 0; n < NSRC; n++) begin : g_order
    assign src_msb[DW-1-n] = src_in[n];
  end

  irq_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (src_msb),
    .q   (sync_q)
  );

  irq_status #(.W(DW)) u_status (
    .clk      (clk),
    .rst      (rst),
    .raw      (sync_q),
    .pol      (pol_q),
    .clr_mask (clr_mask),
    .status   (status_q)
  );

  irq_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .status   (status_q),
    .raw      (sync_q),
    .en       (en_q),
    .pol      (pol_q),
    .acc      (acc_q),
    .clr_mask (clr_mask),
    .rdata    (bus_rdata)
  );

  irq_cascade #(.W(DW)) u_casc (
    .clk    (clk),
    .rst    (rst),
    .status (status_q),
    .en     (en_q),
    .gate   (acc_q[0]),
    .irq    (irq_out)
  );
endmodule

// File: rtl/lvl_irq_agg_chk.sv
module lvl_irq_agg_chk
  import lvl_irq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int AW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [NSRC-1:0] bus_wdata,
  input logic [NSRC-1:0] bus_rdata,
  input logic            irq_out,
  input logic [NSRC-1:0] raw,
  input logic [NSRC-1:0] pol,
  input logic [NSRC-1:0] status,
  input logic [NSRC-1:0] en,
  input logic [NSRC-1:0] acc
);
  logic unmapped;
  assign unmapped = bus_addr != AW'(OFF_ACC) && bus_addr != AW'(OFF_STAT) &&
                    bus_addr != AW'(OFF_EN)  && bus_addr != AW'(OFF_POL)  &&
                    bus_addr != AW'(OFF_RAW);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!irq_out && bus_rdata == '0));

  // R8
  a_r8_cascade: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq_out == $past(acc[0] && (|(status & en))));

  // R5
  a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_STAT)) |=>
      status == (($past(status) & ~$past(bus_wdata)) | $past(raw ^ pol)));

  // R7
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|(raw ^ pol)) |=> ((status & $past(raw ^ pol)) == $past(raw ^ pol)));

  // R6
  a_r6_enable_write: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(OFF_EN)) |=> en == $past(bus_wdata));

  // R11
  a_r11_gate_off: assert property (@(posedge clk) disable iff (rst)
    !acc[0] |=> !irq_out);

  // R10
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> bus_rdata == '0);
endmodule

bind lvl_irq_agg lvl_irq_agg_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .raw       (sync_q),
  .pol       (pol_q),
  .status    (status_q),
  .en        (en_q),
  .acc       (acc_q)
);

// File: tb/lvl_irq_agg_bench.sv
`timescale 1ns/1ps
module lvl_irq_agg_bench;
  localparam int N = 32;
  localparam logic [7:0] A_ACC = 8'h04, A_STAT = 8'h50, A_EN = 8'h54,
                         A_POL = 8'h58, A_RAW = 8'h5C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src_in = '0;
  logic          bus_we = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          irq_out;

  int vectors = 0;
  int errors  = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lvl_irq_agg u_lvl_irq_agg (
    .clk(clk), .rst(rst), .src_in(src_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  // behavioural reference, indexed by source number
  bit m_s1 [N], m_s2 [N], m_st [N], m_en [N], m_pol [N];
  logic [N-1:0] m_acc = '0, m_rd = '0;
  bit m_irq = 1'b0;

  function automatic logic [N-1:0] pack(input bit v [N]);
    logic [N-1:0] r = '0;
    for (int n = 0; n < N; n++) r[N-1-n] = v[n];
    return r;
  endfunction

  always @(posedge clk) begin
    bit n_st [N];
    bit any;
    logic [N-1:0] rd;
    if (rst) begin
      for (int n = 0; n < N; n++) begin
        m_s1[n] = 0; m_s2[n] = 0; m_st[n] = 0; m_en[n] = 0; m_pol[n] = 0;
      end
      m_acc = '0; m_rd = '0; m_irq = 0;
    end else begin
      any = 0;
      for (int n = 0; n < N; n++) begin
        n_st[n] = (m_s2[n] != m_pol[n]) ||
                  (m_st[n] && !(bus_we && bus_addr == A_STAT && bus_wdata[N-1-n]));
        if (m_st[n] && m_en[n]) any = 1;
      end
      case (bus_addr)
        A_ACC:   rd = m_acc;
        A_STAT:  rd = pack(m_st);
        A_EN:    rd = pack(m_en);
        A_POL:   rd = pack(m_pol);
        A_RAW:   rd = pack(m_s2);
        default: rd = '0;
      endcase
      m_rd  = rd;
      m_irq = any && m_acc[0];
      for (int n = 0; n < N; n++) begin
        m_st[n] = n_st[n];
        m_s2[n] = m_s1[n];
        m_s1[n] = src_in[n];
        if (bus_we && bus_addr == A_EN)  m_en[n]  = bus_wdata[N-1-n];
        if (bus_we && bus_addr == A_POL) m_pol[n] = bus_wdata[N-1-n];
      end
      if (bus_we && bus_addr == A_ACC) m_acc = bus_wdata;
    end
  end

  always @(negedge clk) begin
    if (model_on && !rst) begin
      vectors++;
      if (irq_out !== m_irq || bus_rdata !== m_rd) begin
        errors++;
        $display("FAIL R8/R10 model: irq=%0b rdata=%h expected irq=%0b rdata=%h",
                 irq_out, bus_rdata, m_irq, m_rd);
      end
    end
  end

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [N-1:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(bus_rdata, exp, tag);
    bus_addr = 8'h00;
  endtask

  task automatic chk_irq(input bit exp, input string tag);
    chk({{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, exp}, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    chk_irq(1'b0, "R1 irq after reset");
    rd(A_ACC,  '0, "R1 R3 global enable reset");
    rd(A_STAT, '0, "R1 R3 status reset");
    rd(A_EN,   '0, "R1 R3 enable reset");
    rd(A_POL,  '0, "R1 R3 polarity reset");
    rd(A_RAW,  '0, "R3 raw reset");
    rd(8'h10,  '0, "R10 unmapped offset");

    wr(A_EN, 32'hA5A5_0F0F);  rd(A_EN,  32'hA5A5_0F0F, "R6 enable readback");
    wr(A_ACC, 32'h0000_0003); rd(A_ACC, 32'h0000_0003, "R6 global enable readback");
    wr(A_EN, '0); wr(A_ACC, '0);

    // source 0 lands on bit 31
    src_in = 32'h1; idle(4);
    rd(A_RAW,  32'h8000_0000, "R2 R9 raw bit order");
    rd(A_STAT, 32'h8000_0000, "R2 status bit order");
    src_in = '0; idle(4);
    rd(A_STAT, 32'h8000_0000, "R5 latched after input drop");
    wr(A_STAT, 32'h7FFF_FFFF);
    rd(A_STAT, 32'h8000_0000, "R5 zero leaves bit");
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0000_0000, "R5 all ones clears");

    // inverted polarity on source 5 (bit 26) with its line low
    wr(A_POL, 32'h0400_0000); idle(2);
    rd(A_POL,  32'h0400_0000, "R6 polarity readback");
    rd(A_STAT, 32'h0400_0000, "R4 low level asserts when inverted");
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0400_0000, "R7 set wins over clear");
    src_in = 32'h20; idle(4);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, 32'h0000_0000, "R4 high level ignored when inverted");
    rd(A_RAW,  32'h0400_0000, "R9 raw before polarity");
    wr(A_RAW, 32'hFFFF_FFFF);
    rd(A_RAW,  32'h0400_0000, "R9 raw write ignored");

    // cascade on source 3 (bit 28)
    src_in = 32'h28; idle(4);
    rd(A_STAT, 32'h1000_0000, "R7 level source 3 pending");
    chk_irq(1'b0, "R11 all gates off");
    wr(A_EN, 32'h1000_0000); idle(2);
    chk_irq(1'b0, "R11 global enable off");
    wr(A_ACC, 32'h1); idle(2);
    chk_irq(1'b1, "R8 cascade raised");
    wr(A_EN, 32'h2000_0000); idle(2);
    chk_irq(1'b0, "R8 other source enabled only");
    wr(A_EN, 32'h1000_0000); wr(A_ACC, 32'h2); idle(2);
    chk_irq(1'b0, "R8 only bit 0 gates");
    wr(A_ACC, 32'h1); idle(2);
    chk_irq(1'b1, "R8 cascade back");
    src_in = 32'h20; idle(4);
    chk_irq(1'b1, "R8 pending after input drop");
    wr(A_STAT, 32'h1000_0000); idle(2);
    chk_irq(1'b0, "R5 R8 cleared drops cascade");

    // random phase against the reference model
    rst = 1'b1; idle(2); rst = 1'b0;
    model_on = 1'b1;
    for (int i = 0; i < 600; i++) begin
      int pick = $urandom_range(0, 6);
      if ($urandom_range(0, 3) == 0) src_in = $urandom;
      bus_we = ($urandom_range(0, 1) == 1);
      case (pick)
        0: bus_addr = A_ACC;
        1: bus_addr = A_STAT;
        2: bus_addr = A_EN;
        3: bus_addr = A_POL;
        4: bus_addr = A_RAW;
        5: bus_addr = A_STAT;
        default: bus_addr = 8'h20;
      endcase
      bus_wdata = (pick == 0) ? 32'($urandom_range(0, 3)) : $urandom;
      @(negedge clk);
    end
    bus_we = 1'b0;
    idle(2);
    finish_run();
  end
endmodule